// File: doc/BRIEF.md
# Fractional-Rate PWM Channel

This block is one pulse-width-modulated output channel. Its rate comes from a 16-bit phase accumulator, and its duty from a threshold compared against that accumulator. Every clock while the channel runs, the accumulator adds a programmable step. The output period is therefore 65536/step input clocks, and that value need not be a whole number. The output is high while the accumulator's top byte is at or above an 8-bit threshold. A larger threshold gives a shorter high time.

Software sees one 32-bit control word through a simple write strobe and a read bus that is always valid:

- Bit 31 enables the channel.
- Bit 30 requests an update.
- Bits 23:8 hold the step.
- Bits 7:0 hold the threshold.

Step and threshold writes land in shadow fields. While the channel runs, the shadow fields reach the live datapath only at an output-cycle boundary, and only when an update has been requested. New settings therefore never cut a pulse short.

Top module: `frac_pwm_channel`

## Requirements
- R1: While and after synchronous reset, the read word is 0 and the output is low.
- R2: The read word carries enable in bit 31, the pending update flag in bit 30, the shadow step in bits 23:8 and the shadow threshold in bits 7:0. Bits 29:24 always read as zero, whatever was written to them.
- R3: While the channel runs, the accumulator adds the live step every clock. The output period is 65536/step clocks.
- R4: While the channel runs, the output is high exactly when the accumulator's bits 15:8 are greater than or equal to the live threshold.
- R5: While bit 31 is clear, the output is low and the accumulator holds its value.
- R6: A write that sets bit 31 while the channel is disabled copies the shadow fields into the live fields and clears the accumulator to zero. It also clears any pending update. The first output sample after that load compares accumulator value 0.
- R7: While the channel runs, a write to bits 23:0 without bit 30 changes only the shadow fields. The output pattern keeps the old settings.
- R8: A write with bit 30 set makes bit 30 read 1 until the next accumulator wrap past 0xFFFF. At that wrap the shadow fields are copied into the live fields and bit 30 clears itself.
- R9: A written step above 0x8002 is rejected, and bits 23:0 of that write are ignored. A step of exactly 0x8002 is accepted.
- R10: A live step of zero freezes the accumulator. The output then stays at a constant level and no update request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench counts high clocks over whole periods for several step/threshold pairs. These pairs include thresholds of 0 and 0xFF, and steps where the top byte only touches the threshold on one sample. A comparator using the wrong inequality, or the low byte, changes those counts. An update request must survive until a wrap and must not take effect without one. A design that loads early or never clears bit 30 shows a wrong count or a stuck flag.

The limit step 0x8002 and the step just above it are both written. An off-by-one limit either loses the legal value or accepts the illegal one. A zero step must leave a pending request pending forever; a design that treats the frozen state as a cycle start would clear it. Re-enabling must restart at phase zero; a design that keeps the old accumulator value shifts the first high sample.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;

    localparam int REG_W    = 32;
    localparam int STEP_W   = 16;
    localparam int DUTY_W   = 8;
    localparam int ACC_W    = STEP_W;
    localparam int EN_BIT   = 31;
    localparam int UPD_BIT  = 30;
    localparam int STEP_LSB = 8;
    localparam int DUTY_LSB = 0;
    localparam int RSVD_LSB = STEP_LSB + STEP_W;
    localparam int RSVD_MSB = UPD_BIT - 1;
    localparam logic [STEP_W-1:0] STEP_MAX = 16'h8002;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [DUTY_W-1:0] thresh;
    } pwm_cfg_t;

    function automatic pwm_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        pwm_cfg_t c;
        c.step   = w[STEP_LSB +: STEP_W];
        c.thresh = w[DUTY_LSB +: DUTY_W];
        return c;
    endfunction

    function automatic logic step_ok(input logic [STEP_W-1:0] s);
        return s <= STEP_MAX;
    endfunction

    function automatic logic [REG_W-1:0] status_word(input logic en,
                                                     input logic pend,
                                                     input pwm_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[EN_BIT]                = en;
        w[UPD_BIT]               = pend;
        w[STEP_LSB +: STEP_W]    = c.step;
        w[DUTY_LSB +: DUTY_W]    = c.thresh;
        return w;
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import frac_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             load_ack,
    output logic             enable,
    output logic             pending,
    output pwm_cfg_t         shadow,
    output logic [REG_W-1:0] reg_rdata
);

    pwm_cfg_t wr_cfg;
    logic     wr_legal;
    logic     unused_rsvd;

    assign wr_cfg      = cfg_from_word(reg_wdata);
    assign wr_legal    = step_ok(wr_cfg.step);
    assign unused_rsvd = ^reg_wdata[RSVD_MSB:RSVD_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable  <= 1'b0;
            pending <= 1'b0;
            shadow  <= '0;
        end else begin
            if (load_ack) begin
                pending <= 1'b0;
            end
            if (reg_we) begin
                enable <= reg_wdata[EN_BIT];
                if (reg_wdata[UPD_BIT]) begin
                    pending <= 1'b1;
                end
                if (wr_legal) begin
                    shadow <= wr_cfg;
                end
            end
        end
    end

    assign reg_rdata = status_word(enable, pending, shadow);

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pending && !load_ack) |=> pending); // R8

    AST_BAD_STEP: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !step_ok(reg_wdata[STEP_LSB +: STEP_W])) |=> $stable(shadow)); // R9

endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
    import frac_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             pending,
    input  pwm_cfg_t         shadow,
    output logic [ACC_W-1:0] acc,
    output pwm_cfg_t         live,
    output logic             running,
    output logic             load_ack
);

    logic           en_d;
    logic           start;
    logic           wrap;
    logic [ACC_W:0] sum;

    assign start    = enable && !en_d;
    assign running  = enable && en_d;
    assign sum      = {1'b0, acc} + {1'b0, live.step};
    assign wrap     = running && sum[ACC_W];
    assign load_ack = start || (wrap && pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d <= 1'b0;
            acc  <= '0;
            live <= '0;
        end else begin
            en_d <= enable;
            if (start) begin
                acc  <= '0;
                live <= shadow;
            end else if (running) begin
                acc <= sum[ACC_W-1:0];
                if (wrap && pending) begin
                    live <= shadow;
                end
            end
        end
    end

    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |=> (acc == '0)); // R6

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        load_ack |=> (live == $past(shadow))); // R8

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(acc)); // R5

    AST_ZERO_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (running && live.step == '0) |=> $stable(acc)); // R10

endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
    import frac_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              running,
    input  logic [DUTY_W-1:0] phase_hi,
    input  logic [DUTY_W-1:0] thresh,
    output logic              pwm_out
);

    assign pwm_out = running && (phase_hi >= thresh);

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> !pwm_out); // R5

endmodule

// File: rtl/frac_pwm_channel.sv
module frac_pwm_channel
    import frac_pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pwm_out
);

    logic             enable;
    logic             pending;
    logic             load_ack;
    logic             running;
    pwm_cfg_t         shadow;
    pwm_cfg_t         live;
    logic [ACC_W-1:0] acc;

    pwm_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .load_ack  (load_ack),
        .enable    (enable),
        .pending   (pending),
        .shadow    (shadow),
        .reg_rdata (reg_rdata)
    );

    pwm_phase_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .pending  (pending),
        .shadow   (shadow),
        .acc      (acc),
        .live     (live),
        .running  (running),
        .load_ack (load_ack)
    );

    pwm_duty_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .running  (running),
        .phase_hi (acc[ACC_W-1 -: DUTY_W]),
        .thresh   (live.thresh),
        .pwm_out  (pwm_out)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we) |-> (reg_rdata[RSVD_MSB:RSVD_LSB] == '0)); // R2

endmodule

// File: tb/test_frac_pwm_channel.sv
module test_frac_pwm_channel;

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;
    localparam int NVEC = 8;
    // {step[55:40], thresh[39:32], samples[31:16], expected_high[15:0]}
    localparam logic [55:0] VEC [NVEC] = '{
        {16'h1000, 8'h80, 16'd32,  16'd16},
        {16'h1000, 8'h00, 16'd16,  16'd16},
        {16'h1000, 8'hFF, 16'd16,  16'd0},
        {16'h2000, 8'h40, 16'd16,  16'd12},
        {16'h0100, 8'hC0, 16'd256, 16'd64},
        {16'h8000, 8'h80, 16'd16,  16'd8},
        {16'h4000, 8'hC0, 16'd16,  16'd4},
        {16'h0800, 8'h10, 16'd32,  16'd30}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    frac_pwm_channel i_frac_pwm_channel (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] word(input logic [15:0] s, input logic [7:0] t);
        return {8'h00, s, t};
    endfunction

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        check("R1 reset rdata", reg_rdata, 32'h0);
        check("R1 reset out", {31'h0, pwm_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset rdata", reg_rdata, 32'h0);

        // vector table: R3/R4 rate and duty, R6 restart from phase zero
        for (int v = 0; v < NVEC; v++) begin
            wr(32'h0);
            wr(EN | word(VEC[v][55:40], VEC[v][39:32]));
            check("R2 readback", reg_rdata, EN | word(VEC[v][55:40], VEC[v][39:32]));
            @(negedge clk);
            count_high(int'(VEC[v][31:16]), hi);
            check($sformatf("R3/R4 vec%0d high count", v), hi, {16'h0, VEC[v][15:0]});
        end

        // R6: re-enable restarts at accumulator zero
        wr(32'h0);
        wr(EN | word(16'h1000, 8'h80));
        @(negedge clk);
        check("R6 first sample low", {31'h0, pwm_out}, 32'h0);
        repeat (8) @(negedge clk);
        check("R6 ninth sample high", {31'h0, pwm_out}, 32'h1);

        // R7: shadow write without request keeps old pattern
        wr(EN | word(16'h2000, 8'h40));
        check("R7 shadow readback", reg_rdata, EN | word(16'h2000, 8'h40));
        count_high(32, hi);
        check("R7 old pattern kept", hi, 32'd16);

        // R8: request pends until wrap, then applies
        wr(EN | UPD | word(16'h2000, 8'h40));
        check("R8 pending visible", {31'h0, reg_rdata[30]}, 32'h1);
        repeat (20) @(negedge clk);
        check("R8 pending cleared", {31'h0, reg_rdata[30]}, 32'h0);
        count_high(16, hi);
        check("R8 new pattern", hi, 32'd12);

        // R2: reserved bits read zero
        wr(EN | 32'h3F00_0000 | word(16'h2000, 8'h40));
        check("R2 reserved zero", {26'h0, reg_rdata[29:24]}, 32'h0);

        // R9: step limit
        wr(EN | word(16'h8003, 8'h11));
        check("R9 illegal step ignored", {8'h0, reg_rdata[23:0]}, word(16'h2000, 8'h40));
        wr(EN | word(16'h8002, 8'h11));
        check("R9 limit step accepted", {8'h0, reg_rdata[23:0]}, word(16'h8002, 8'h11));

        // R10: zero step freezes
        wr(32'h0);
        wr(EN | word(16'h0000, 8'h00));
        @(negedge clk);
        count_high(40, hi);
        check("R10 frozen high", hi, 32'd40);
        wr(EN | UPD | word(16'h0000, 8'h01));
        repeat (50) @(negedge clk);
        check("R10 request stays pending", {31'h0, reg_rdata[30]}, 32'h1);
        check("R10 output unchanged", {31'h0, pwm_out}, 32'h1);

        // R5: disabled output low
        wr(32'h0);
        wr(EN | word(16'h1000, 8'h00));
        @(negedge clk);
        check("R5 running high", {31'h0, pwm_out}, 32'h1);
        wr(word(16'h1000, 8'h00));
        count_high(40, hi);
        check("R5 disabled low", hi, 32'd0);
        check("R5 enable bit clear", {31'h0, reg_rdata[31]}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule